// File: doc/BRIEF.md
# Multi-Channel Three-Wire Audio Serializer

This block turns up to four channels of left/right PCM samples into three-wire serial audio. All channels share one bit clock and one word-select (LR) clock. Both clocks come from one of two master-clock tick strobes, which runs through a programmable divider. Each channel takes a 32-bit word per half-frame. It pulls a 16-, 20- or 24-bit sample out of that word from either the low or the high end, and shifts the sample out MSB first.

A master control word sets the channel enables, the divider code, the master-clock choice and two output disables. It is written through a one-cycle write strobe. Sample words enter on a per-channel valid/ready port. The block asserts ready for exactly one cycle at the start of each half-frame of a running or starting channel, and takes the word in that cycle. It cannot wait: if valid is low at that moment, the channel sends silence for that half-frame. A producer that holds a word until it sees ready never loses data, but it must have the word ready in time. Mutes and per-channel sample formats are plain level inputs.

Top module: `audser_top`

## Requirements
- R1: Divider code `cfg[23:20]` sets the bit-clock period in selected master ticks: code 1 gives 2, code 2 gives 4, code 4 gives 8, code 6 gives 12. Every other code behaves as code 1. The bit clock toggles only in a cycle with a selected tick.
- R2: `cfg[24]` picks the divider input: 0 selects `mck0_tick`, 1 selects `mck1_tick`.
- R3: A frame is 64 bit-clock periods. LRCK is low for the 32 left slots and high for the 32 right slots. LRCK and serial data change only in the cycle in which the bit clock falls.
- R4: In each half-frame, slot 0 carries 0, slots 1..W carry the sample MSB first, and later slots carry 0. Width code `ch_mode` per channel: 0 is 16 bits, 2 is 20 bits, 3 is 24 bits, and the reserved code 1 is 16 bits.
- R5: A 16-bit sample is `word[15:0]`. A 20- or 24-bit sample is the low W bits when `ch_msb` is 0 and `word[31:32-W]` when it is 1.
- R6: Channel n is enabled by `cfg[31-n]`. A channel enabled in mid-frame starts at the next left-frame start, so channels enabled together start on the same slot.
- R7: `run_o[n]` rises at the first frame start that sees the enable set. It falls at the first frame start that sees the enable clear, and the channel's data stays 0 from then on.
- R8: Channel n is muted by `mute[3-n]`, by the all-serial mute `mute[13]` or by the all-audio mute `mute[15]`. A muted channel drives 0 on its data pin, while clocks, requests and run flags go on unchanged.
- R9: `cfg[11]` holds `bclk_o` low and `cfg[10]` holds `lrck_o` low. After reset the control word is 0x0010_0C00: both disables set, no channel enabled, code 1, master clock 0.
- R10: `smp_ready[n]` is high for one cycle, in the cycle of the bit-clock fall that opens a half-frame, for a channel that is running or starting. The word is taken in that cycle if `smp_valid[n]` is high. Otherwise the half-frame carries zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mck0_tick | input | 1 | Master clock 0 strobe |
| mck1_tick | input | 1 | Master clock 1 strobe |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| ch_mode | input | 2*NCH | Per-channel width code, channel n at [2n+1:2n] |
| ch_msb | input | NCH | Per-channel high-end placement select |
| mute | input | 16 | Mute controls |
| smp_valid | input | NCH | Sample word valid per channel |
| smp_data | input | 32*NCH | Sample words, channel n at [32n+31:32n] |
| smp_ready | output | NCH | Sample take strobe per channel |
| run_o | output | NCH | Channel running flags |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | LR clock |
| sdout_o | output | NCH | Serial data per channel |

## Verification
`smp_ready` is combinational and is due in the same cycle as the tick that completes a high bit-clock phase. `bclk_o`, `lrck_o`, the registered data bit and `run_o` change at the clock edge that ends that cycle. Mutes and output disables act in the same cycle. The bench drives inputs at the falling edge and samples every output 1 ns later. At that point the registered outputs reflect the last rising edge, and the combinational outputs reflect the inputs for the next one. The behavioural model follows the same split: it advances its state at each rising edge and forms its combinational expectations from the current inputs.

// File: rtl/audser_pkg.sv
package audser_pkg;

  localparam int unsigned CFG_W      = 32;
  localparam int unsigned EN_TOP     = 31;
  localparam int unsigned MCKSEL_BIT = 24;
  localparam int unsigned RATE_LSB   = 20;
  localparam int unsigned RATE_W     = 4;
  localparam int unsigned BCLK_OFF   = 11;
  localparam int unsigned LRCK_OFF   = 10;
  localparam int unsigned MUTE_W     = 16;
  localparam int unsigned MUTE_SER   = 13;
  localparam int unsigned MUTE_ALL   = 15;
  localparam logic [CFG_W-1:0] CFG_RST = 32'h0010_0C00;

  // half bit-clock period in master ticks for a divider code
  function automatic logic [RATE_W-1:0] half_ticks(input logic [RATE_W-1:0] code);
    case (code)
      4'd2:    half_ticks = 4'd2;
      4'd4:    half_ticks = 4'd4;
      4'd6:    half_ticks = 4'd6;
      default: half_ticks = 4'd1;
    endcase
  endfunction

  // sample width for a width code, reserved code folds onto 16
  function automatic logic [4:0] bits_of(input logic [1:0] code);
    case (code)
      2'd2:    bits_of = 5'd20;
      2'd3:    bits_of = 5'd24;
      default: bits_of = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/audser_clkdiv.sv
module audser_clkdiv
  import audser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] half,
  output logic              bclk,
  output logic              fall
);

  logic [RATE_W-1:0] mcnt;
  logic              wrap;

  assign wrap = tick && (({1'b0, mcnt} + 5'd1) >= {1'b0, half});
  assign fall = wrap && bclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        mcnt <= '0;
        bclk <= ~bclk;
      end else begin
        mcnt <= mcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/audser_framer.sv
module audser_framer #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  output logic [SLOT_W:0]   cnt,
  output logic [SLOT_W-1:0] slot_next,
  output logic              frame_start,
  output logic              half_start,
  output logic              lrck
);

  logic [SLOT_W:0] nxt;

  assign nxt         = cnt + 1'b1;
  assign slot_next   = nxt[SLOT_W-1:0];
  assign frame_start = fall && (nxt == '0);
  assign half_start  = fall && (slot_next == '0);
  assign lrck        = cnt[SLOT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (fall) cnt <= nxt;
  end

endmodule

// File: rtl/audser_lane.sv
module audser_lane
  import audser_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SHIFT_W = 24,
  parameter int unsigned SLOT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              frame_start,
  input  logic              half_start,
  input  logic [SLOT_W-1:0] slot_next,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              msb_side,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              ready,
  output logic              run,
  output logic              sd
);

  logic              start;
  logic [4:0]        w_q;
  logic [4:0]        nb;
  logic [SHIFT_W-1:0] shreg;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] just;

  assign start = frame_start ? en : (half_start && run);
  assign ready = start;

  always_comb begin
    nb  = bits_of(mode);
    raw = valid ? word : '0;
    if (msb_side && (nb != 5'd16))
      picked = raw >> (WORD_W - 32'(nb));
    else
      picked = raw & ((WORD_W'(1) << nb) - WORD_W'(1));
    just = picked << (SHIFT_W - 32'(nb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      sd    <= 1'b0;
      w_q   <= 5'd16;
      shreg <= '0;
    end else if (fall) begin
      if (frame_start) run <= en;
      if (half_start) begin
        sd <= 1'b0;
        if (start) begin
          shreg <= just[SHIFT_W-1:0];
          w_q   <= nb;
        end
      end else if (run && ({1'b0, slot_next} <= {1'b0, w_q})) begin
        sd    <= shreg[SHIFT_W-1];
        shreg <= {shreg[SHIFT_W-2:0], 1'b0};
      end else begin
        sd <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audser_top.sv
module audser_top
  import audser_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mck0_tick,
  input  logic                  mck1_tick,
  input  logic                  cfg_wr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic [2*NCH-1:0]      ch_mode,
  input  logic [NCH-1:0]        ch_msb,
  input  logic [MUTE_W-1:0]     mute,
  input  logic [NCH-1:0]        smp_valid,
  input  logic [NCH*WORD_W-1:0] smp_data,
  output logic [NCH-1:0]        smp_ready,
  output logic [NCH-1:0]        run_o,
  output logic                  bclk_o,
  output logic                  lrck_o,
  output logic [NCH-1:0]        sdout_o
);

  localparam int unsigned SLOT_W  = 5;
  localparam int unsigned SHIFT_W = 24;

  logic [CFG_W-1:0]  mcfg_q;
  logic              tick_sel;
  logic [RATE_W-1:0] half;
  logic              bclk_q;
  logic              fall;
  logic [SLOT_W:0]   cnt_q;
  logic [SLOT_W-1:0] slot_next;
  logic              frame_start;
  logic              half_start;
  logic              lrck_q;
  logic [NCH-1:0]    sd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mcfg_q <= CFG_RST;
    else if (cfg_wr) mcfg_q <= cfg_wdata;
  end

  assign tick_sel = mcfg_q[MCKSEL_BIT] ? mck1_tick : mck0_tick;
  assign half     = half_ticks(mcfg_q[RATE_LSB +: RATE_W]);

  audser_clkdiv u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_sel),
    .half (half),
    .bclk (bclk_q),
    .fall (fall)
  );

  audser_framer #(.SLOT_W(SLOT_W)) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (fall),
    .cnt        (cnt_q),
    .slot_next  (slot_next),
    .frame_start(frame_start),
    .half_start (half_start),
    .lrck       (lrck_q)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic muted;
      assign muted = mute[3-i] | mute[MUTE_SER] | mute[MUTE_ALL];

      audser_lane #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .SLOT_W(SLOT_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .frame_start(frame_start),
        .half_start (half_start),
        .slot_next  (slot_next),
        .en         (mcfg_q[EN_TOP-i]),
        .mode       (ch_mode[2*i +: 2]),
        .msb_side   (ch_msb[i]),
        .valid      (smp_valid[i]),
        .word       (smp_data[WORD_W*i +: WORD_W]),
        .ready      (smp_ready[i]),
        .run        (run_o[i]),
        .sd         (sd_q[i])
      );

      assign sdout_o[i] = sd_q[i] & ~muted;
    end
  endgenerate

  assign bclk_o = bclk_q & ~mcfg_q[BCLK_OFF];
  assign lrck_o = lrck_q & ~mcfg_q[LRCK_OFF];

endmodule

// File: rtl/audser_chk.sv
module audser_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bclk_o,
  input logic           lrck_o,
  input logic [NCH-1:0] sdout_o,
  input logic [NCH-1:0] smp_ready,
  input logic [NCH-1:0] run_o,
  input logic [5:0]     cnt_q,
  input logic           tick_sel,
  input logic           bclk_q,
  input logic [31:0]    mcfg_q
);

  // R1: bit clock moves only after a selected master tick
  a_r1_toggle_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_q) |-> $past(tick_sel));

  // R3: visible LR clock changes together with a visible bit-clock fall
  a_r3_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcfg_q[10] && !mcfg_q[11] && $stable(mcfg_q) && !$stable(lrck_o)) |-> $fell(bclk_o));

  // R4: slot 0 of each half-frame is silent
  a_r4_slot0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[4:0] == 5'd0) |-> (sdout_o == '0));

  // R7: run flags change only on entering a left frame
  a_r7_run_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o != $past(run_o)) |-> (cnt_q == 6'd0));

  // R10: requests appear only in the last slot before a half-frame boundary
  a_r10_ready_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (|smp_ready) |-> (cnt_q[4:0] == 5'd31));

endmodule

bind audser_top audser_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bclk_o   (bclk_o),
  .lrck_o   (lrck_o),
  .sdout_o  (sdout_o),
  .smp_ready(smp_ready),
  .run_o    (run_o),
  .cnt_q    (cnt_q),
  .tick_sel (tick_sel),
  .bclk_q   (bclk_q),
  .mcfg_q   (mcfg_q)
);

// File: tb/audser_top_test.sv
`timescale 1ns/1ps
module audser_top_test;

  localparam int NCH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mck0_tick = 1'b1;
  logic         mck1_tick = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [31:0]  cfg_wdata = '0;
  logic [7:0]   ch_mode = '0;
  logic [3:0]   ch_msb = '0;
  logic [15:0]  mute = '0;
  logic [3:0]   smp_valid = '0;
  logic [127:0] smp_data = '0;
  logic [3:0]   smp_ready;
  logic [3:0]   run_o;
  logic         bclk_o;
  logic         lrck_o;
  logic [3:0]   sdout_o;

  always #4 clk = ~clk;

  audser_top #(.NCH(NCH), .WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .mck0_tick(mck0_tick), .mck1_tick(mck1_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ch_mode(ch_mode), .ch_msb(ch_msb),
    .mute(mute), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .run_o(run_o), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdout_o(sdout_o)
  );

  int    ncmp = 0;
  int    nbad = 0;
  string phase = "R9 reset";
  bit    done = 0;

  // behavioural reference state
  int        m_mcnt, m_cnt;
  bit        m_bclk;
  bit [31:0] m_cfg;
  bit        m_run [4];
  bit        m_sd  [4];
  bit [31:0] m_samp[4];
  int        m_pos [4];

  function automatic int half_of(bit [3:0] c);
    if (c == 2) return 2;
    if (c == 4) return 4;
    if (c == 6) return 6;
    return 1;
  endfunction

  function automatic int width_of(bit [1:0] m);
    if (m == 2) return 20;
    if (m == 3) return 24;
    return 16;
  endfunction

  function automatic bit [31:0] extract(bit [31:0] wd, int w, bit hi);
    bit [31:0] mask = (32'h1 << w) - 1;
    if (hi && w != 16) return (wd >> (32 - w)) & mask;
    return wd & mask;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mcnt = 0; m_cnt = 0; m_bclk = 0; m_cfg = 32'h0010_0C00;
      for (int c = 0; c < 4; c++) begin
        m_run[c] = 0; m_sd[c] = 0; m_samp[c] = 0; m_pos[c] = -1;
      end
    end else begin
      int hv;
      bit tk, fl;
      hv = half_of(m_cfg[23:20]);
      tk = m_cfg[24] ? mck1_tick : mck0_tick;
      fl = 0;
      if (tk) begin
        if (m_mcnt + 1 >= hv) begin
          m_mcnt = 0; fl = m_bclk; m_bclk = !m_bclk;
        end else m_mcnt++;
      end
      if (fl) begin
        int nx;
        nx = (m_cnt + 1) % 64;
        for (int c = 0; c < 4; c++) begin
          bit en;
          en = m_cfg[31-c];
          if (nx % 32 == 0) begin
            bit st;
            st = (nx == 0) ? en : m_run[c];
            if (nx == 0) m_run[c] = en;
            m_sd[c] = 0; m_pos[c] = -1;
            if (st) begin
              int w;
              w = width_of(ch_mode[2*c +: 2]);
              m_samp[c] = extract(smp_valid[c] ? smp_data[32*c +: 32] : 32'h0, w, ch_msb[c]);
              m_pos[c] = w - 1;
            end
          end else if (m_run[c] && m_pos[c] >= 0) begin
            m_sd[c] = m_samp[c][m_pos[c]];
            m_pos[c]--;
          end else m_sd[c] = 0;
        end
        m_cnt = nx;
      end
      if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  task automatic chk(string what, int got, int exp);
    ncmp++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s at %0t: got %0h expected %0h", phase, what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int hv;
      bit tk, fn;
      int nx;
      bit [3:0] er, es;
      hv = half_of(m_cfg[23:20]);
      tk = m_cfg[24] ? mck1_tick : mck0_tick;
      fn = tk && (m_mcnt + 1 >= hv) && m_bclk;
      nx = (m_cnt + 1) % 64;
      for (int c = 0; c < 4; c++) begin
        bit mu;
        er[c] = fn && ((nx == 0) ? m_cfg[31-c] : ((nx == 32) ? m_run[c] : 1'b0));
        mu = mute[3-c] | mute[13] | mute[15];
        es[c] = m_sd[c] & !mu;
      end
      chk("bclk R1", int'(bclk_o), int'(m_bclk & !m_cfg[11]));
      chk("lrck R3", int'(lrck_o), int'((m_cnt >= 32) & !m_cfg[10]));
      chk("sdout R4", int'(sdout_o), int'(es));
      chk("run R7", int'(run_o), int'({m_run[3], m_run[2], m_run[1], m_run[0]}));
      chk("ready R10", int'(smp_ready), int'(er));
    end
  end

  // master tick 1 every third cycle, fresh sample words every cycle
  int tph = 0;
  always @(negedge clk) begin
    tph = (tph + 1) % 3;
    mck1_tick = (tph == 0);
    smp_data = {$urandom, $urandom, $urandom, $urandom};
  end

  task automatic wcfg(bit [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog R1: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    smp_valid = 4'hF;
    ch_mode = {2'd1, 2'd2, 2'd3, 2'd0};
    ch_msb  = 4'b0010;
    idle(4);
    #1;
    // R9: reset outputs
    chk("reset outputs R9", int'({bclk_o, lrck_o, sdout_o, run_o, smp_ready}), 0);
    @(negedge clk);
    rst_n = 1;
    idle(200);
    chk("idle run R9", int'(run_o), 0);
    phase = "R3/R4/R6/R7/R10 ch0 ch1";
    wcfg(32'hC010_0000);
    idle(400);
    phase = "R5/R6 mid-frame join all";
    idle(37);
    ch_msb = 4'b0100;
    wcfg(32'hF010_0000);
    idle(500);
    phase = "R1 code2";  wcfg(32'hF020_0000); idle(900);
    phase = "R1 code4";  wcfg(32'hF040_0000); idle(1200);
    phase = "R1 code6";  wcfg(32'hF060_0000); idle(1700);
    phase = "R1 code3";  wcfg(32'hF030_0000); idle(400);
    phase = "R2 mck1";   wcfg(32'hF110_0000); idle(900);
    phase = "R8 mutes";
    wcfg(32'hF010_0000);
    mute = 16'h0008; idle(200);
    mute = 16'h2000; idle(200);
    mute = 16'h8000; idle(200);
    mute = 16'h0001; idle(200);
    mute = 16'h0000;
    phase = "R10 no valid";
    smp_valid = 4'b0101; idle(300);
    smp_valid = 4'hF;
    phase = "R5 formats swap";
    ch_mode = {2'd3, 2'd3, 2'd2, 2'd2}; ch_msb = 4'b1010; idle(400);
    phase = "R7 stop";   wcfg(32'h0010_0000); idle(300);
    chk("stopped R7", int'(run_o), 0);
    phase = "R9 disables"; wcfg(32'hF010_0C00); idle(300);
    wcfg(32'hF010_0800); idle(300);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

endmodule